// File: doc/BRIEF.md
# Coarse-Fine Event Time Digitizer

This block assigns an arrival time to a discriminator strobe that is not synchronous to the system clock. A free-running binary counter advances once per clock period of 16 ns and supplies the upper bits of the time stamp. A tapped delay chain of ten elements, about 2 ns each, is modelled outside the block. It presents a thermometer pattern that shows how far the strobe edge has travelled since it arrived. When the block first sees the strobe high, it takes the tap pattern and the counter value in the same clock cycle.

Next, the block locates the first 1-to-0 transition in the latched pattern. This gives the lag, meaning the number of taps the edge has crossed. It then moves the coarse value back by zero, one or two clock periods, so that the combined number counts true arrival time in 2 ns units. The result, with the coarse field above the fine field, appears on a registered output with a single-cycle valid pulse. While an event is still in the pipeline, any further strobe edge is dropped.

Top module: `tdc_event_stamp`

## Requirements
- R1: After reset the coarse counter starts at 0 and increases by exactly 1 on every clock edge, wrapping modulo 2^COARSE_W. The value C taken for an event is the counter value held just before the capture edge.
- R2: A capture happens on the first clock edge that samples the strobe high after it was sampled low. The tap pattern and C are latched at that edge. Later changes to the tap input have no effect on that event's stamp.
- R3: The lag k is the index of the lowest tap that reads 0, where tap 0 is nearest the strobe input. All zeros gives k=0 and all ones gives k=NTAPS. A bubble such as 0000111011 (tap 0 is the rightmost bit) gives the first transition, here k=2.
- R4: The stamp equals C*2^FINE_W - k, modulo 2^(COARSE_W+FINE_W). The fine field is the low FINE_W bits, in 2 ns units (FINE_W=3, so 8 taps per period). For k=0 the coarse field is C. For 1<=k<=8 it is C-1. For k>=9 it is C-2.
- R5: stamp_vld_o is high for exactly one cycle. It is seen after the second clock edge that follows the capture edge, and the new stamp appears together with it.
- R6: A strobe rise sampled on either of the two edges after a capture is ignored: it produces no second valid and leaves the stamp unchanged. A rise sampled on the third edge after a capture is accepted.
- R7: A strobe held high for many cycles yields one event only.
- R8: Reset clears the counter, the latch and the pipeline. An event in flight when reset is asserted never produces a valid, and stamp_o reads 0 with valid low.
- R9: An event with C=0 and k>0 wraps: C=0, k=3 gives stamp 32765 (coarse 4095, fine 5) at default widths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 16 ns period in the target |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe_i | input | 1 | Discriminator timing strobe |
| taps_i | input | NTAPS | Delay-chain thermometer pattern, bit 0 nearest the strobe |
| stamp_o | output | COARSE_W+FINE_W | Combined time stamp, coarse field above fine field |
| stamp_vld_o | output | 1 | One-cycle pulse marking a new stamp |

## Verification
The bench feeds tap patterns for lag 0, lag exactly one period (8), lags 9 and 10 that cross two periods, and a bubbled pattern. A decoder that counted ones or chose the last transition would give the wrong fine field. A design that missed the one- or two-period correction would show a coarse field that is one or two too high. Events are fired at counter values 0 and 4095, around the wrap, which catches borrow errors. Rises during the dead window, a held strobe, and a reset during a pending event show whether a design double-counts, retriggers on level, or leaks a stale valid. Each event also scrambles the tap input after capture, so a design that does not actually latch the pattern is caught.

// File: rtl/tdc_stamp_pkg.sv
package tdc_stamp_pkg;
  // Number of clock periods the coarse sample is moved back by.
  typedef enum logic [1:0] {
    CORR_NONE = 2'd0,
    CORR_ONE  = 2'd1,
    CORR_TWO  = 2'd2
  } corr_e;
endpackage

// File: rtl/tdc_coarse_ctr.sv
module tdc_coarse_ctr #(
  parameter int unsigned COARSE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [COARSE_W-1:0] count_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) count_o <= '0;
    else        count_o <= count_o + 1'b1;
  end

  AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> count_o == $past(count_o) + 1'b1); // R1
endmodule

// File: rtl/tdc_tap_latch.sv
module tdc_tap_latch #(
  parameter int unsigned NTAPS    = 10,
  parameter int unsigned COARSE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strobe_i,
  input  logic [NTAPS-1:0]    taps_i,
  input  logic [COARSE_W-1:0] count_i,
  input  logic                busy_i,
  output logic                held_o,
  output logic [NTAPS-1:0]    taps_o,
  output logic [COARSE_W-1:0] coarse_o
);
  logic strobe_d;
  logic strobe_rise;
  logic capture;

  assign strobe_rise = strobe_i & ~strobe_d;
  assign capture     = strobe_rise & ~busy_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_d <= 1'b0;
      held_o   <= 1'b0;
      taps_o   <= '0;
      coarse_o <= '0;
    end else begin
      strobe_d <= strobe_i;
      held_o   <= capture;
      if (capture) begin
        taps_o   <= taps_i;
        coarse_o <= count_i;
      end
    end
  end

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> !capture); // R7
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(taps_o) && $stable(coarse_o)); // R2
endmodule

// File: rtl/tdc_therm_decode.sv
module tdc_therm_decode
  import tdc_stamp_pkg::*;
#(
  parameter int unsigned NTAPS    = 10,
  parameter int unsigned COARSE_W = 12,
  parameter int unsigned FINE_W   = 3,
  localparam int unsigned LAG_W   = $clog2(NTAPS + 1),
  localparam int unsigned TPC     = 1 << FINE_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                held_i,
  input  logic [NTAPS-1:0]    taps_i,
  input  logic [COARSE_W-1:0] coarse_i,
  output logic                dec_vld_o,
  output logic [LAG_W-1:0]    lag_o,
  output corr_e               corr_o,
  output logic [COARSE_W-1:0] coarse_o
);
  // Position of the first tap that the edge has not reached.
  function automatic logic [LAG_W-1:0] first_gap(input logic [NTAPS-1:0] t);
    logic [LAG_W-1:0] pos;
    logic             seen;
    pos  = LAG_W'(NTAPS);
    seen = 1'b0;
    for (int unsigned i = 0; i < NTAPS; i++) begin
      if (!seen && !t[i]) begin
        pos  = LAG_W'(i);
        seen = 1'b1;
      end
    end
    return pos;
  endfunction

  // How many whole periods lie between arrival and the capture edge.
  function automatic corr_e wrap_class(input logic [LAG_W-1:0] lag);
    if (lag == '0)                    return CORR_NONE;
    else if (lag <= LAG_W'(TPC))      return CORR_ONE;
    else                              return CORR_TWO;
  endfunction

  logic [LAG_W-1:0] lag_now;
  assign lag_now = first_gap(taps_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_vld_o <= 1'b0;
      lag_o     <= '0;
      corr_o    <= CORR_NONE;
      coarse_o  <= '0;
    end else begin
      dec_vld_o <= held_i;
      if (held_i) begin
        lag_o    <= lag_now;
        corr_o   <= wrap_class(lag_now);
        coarse_o <= coarse_i;
      end
    end
  end

  AST_LAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld_o |-> lag_o <= LAG_W'(NTAPS)); // R3
  AST_ZERO_LAG_NO_CORR: assert property (@(posedge clk) disable iff (!rst_n)
    dec_vld_o && corr_o == CORR_NONE |-> lag_o == '0); // R4
endmodule

// File: rtl/tdc_event_stamp.sv
module tdc_event_stamp
  import tdc_stamp_pkg::*;
#(
  parameter int unsigned NTAPS    = 10,
  parameter int unsigned COARSE_W = 12,
  parameter int unsigned FINE_W   = 3,
  localparam int unsigned LAG_W   = $clog2(NTAPS + 1),
  localparam int unsigned SW      = COARSE_W + FINE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_i,
  input  logic [NTAPS-1:0] taps_i,
  output logic [SW-1:0]    stamp_o,
  output logic             stamp_vld_o
);
  // Coarse moved back by the correction, fine field is minus lag mod one period.
  function automatic logic [SW-1:0] merge(input logic [COARSE_W-1:0] c,
                                          input corr_e corr,
                                          input logic [LAG_W-1:0] lag);
    logic [COARSE_W-1:0] c_adj;
    logic [FINE_W-1:0]   f;
    unique case (corr)
      CORR_ONE: c_adj = c - COARSE_W'(1);
      CORR_TWO: c_adj = c - COARSE_W'(2);
      default:  c_adj = c;
    endcase
    f = FINE_W'(0) - FINE_W'(lag);
    return {c_adj, f};
  endfunction

  logic [COARSE_W-1:0] count;
  logic                held;
  logic [NTAPS-1:0]    taps_q;
  logic [COARSE_W-1:0] coarse_q;
  logic                dec_vld;
  logic [LAG_W-1:0]    lag;
  corr_e               corr;
  logic [COARSE_W-1:0] coarse_d;
  logic                busy;

  assign busy = held | dec_vld;

  tdc_coarse_ctr #(.COARSE_W(COARSE_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .count_o (count)
  );

  tdc_tap_latch #(.NTAPS(NTAPS), .COARSE_W(COARSE_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe_i (strobe_i),
    .taps_i   (taps_i),
    .count_i  (count),
    .busy_i   (busy),
    .held_o   (held),
    .taps_o   (taps_q),
    .coarse_o (coarse_q)
  );

  tdc_therm_decode #(.NTAPS(NTAPS), .COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .held_i    (held),
    .taps_i    (taps_q),
    .coarse_i  (coarse_q),
    .dec_vld_o (dec_vld),
    .lag_o     (lag),
    .corr_o    (corr),
    .coarse_o  (coarse_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stamp_o     <= '0;
      stamp_vld_o <= 1'b0;
    end else begin
      stamp_vld_o <= dec_vld;
      if (dec_vld) stamp_o <= merge(coarse_d, corr, lag);
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    stamp_vld_o |=> !stamp_vld_o); // R5
  AST_STAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !stamp_vld_o |-> $stable(stamp_o)); // R6
  AST_NO_VALID_WHILE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !stamp_vld_o); // R5
endmodule

// File: tb/sim_tdc_event_stamp.sv
module sim_tdc_event_stamp;
  localparam int NT = 10;
  localparam int CW = 12;
  localparam int SW = 15;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          strobe = 1'b0;
  logic [NT-1:0] taps = '0;
  logic [SW-1:0] stamp;
  logic          vld;
  logic [CW-1:0] bcnt;
  int            n_chk = 0;
  int            n_bad = 0;
  bit            done = 0;

  always #4 clk = ~clk;

  tdc_event_stamp u0 (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .taps_i(taps),
    .stamp_o(stamp), .stamp_vld_o(vld)
  );

  // Reference time base from R1.
  always @(posedge clk) begin
    if (!rst_n) bcnt <= '0;
    else        bcnt <= bcnt + 1'b1;
  end

  localparam logic [NT-1:0] VEC [8] = '{
    10'b0000000000, 10'b0000000001, 10'b0000000111, 10'b0011111111,
    10'b0111111111, 10'b1111111111, 10'b0000111011, 10'b1011111110 };
  localparam int GAP [8] = '{1, 3, 0, 7, 2, 5, 4, 11};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lag_of(input logic [NT-1:0] v);
    int n = 0;
    while (n < NT && v[n]) n++;
    return n;
  endfunction

  function automatic logic [SW-1:0] expect_stamp(input logic [CW-1:0] c, input int k);
    return {c, 3'b000} - SW'(k);
  endfunction

  // Called at a falling edge; fires one event and checks its timing and value.
  task automatic event_chk(input logic [NT-1:0] v, input string req);
    logic [CW-1:0] c;
    logic [SW-1:0] e;
    c = bcnt;
    e = expect_stamp(c, lag_of(v));
    strobe = 1'b1; taps = v;
    @(negedge clk); strobe = 1'b0; taps = ~v;   // R2: later taps must not matter
    chk(vld == 1'b0, "R5 early", int'(vld), 0);
    @(negedge clk);
    chk(vld == 1'b0, "R5 early", int'(vld), 0);
    @(negedge clk);
    chk(vld == 1'b1, "R5 valid", int'(vld), 1);
    chk(stamp == e, req, int'(stamp), int'(e));
    @(negedge clk);
    chk(vld == 1'b0, "R5 pulse", int'(vld), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int nv;
    logic [SW-1:0] last;
    repeat (3) @(negedge clk);
    chk(vld == 1'b0, "R8 reset valid", int'(vld), 0);
    chk(stamp == '0, "R8 reset stamp", int'(stamp), 0);

    // R9: event at counter value 0 with k=3 wraps.
    rst_n = 1'b1;
    event_chk(10'b0000000111, "R9 wrap");
    chk(stamp == 15'd32765, "R9 literal", int'(stamp), 32765);

    for (int i = 0; i < 8; i++) begin
      repeat (GAP[i]) @(negedge clk);
      event_chk(VEC[i], "R3/R4 table");
    end

    // R1 and R4 around the counter wrap.
    while (bcnt != 12'hFFF) @(negedge clk);
    event_chk(10'b0000000000, "R1 top");
    while (bcnt != 12'h000) @(negedge clk);
    event_chk(10'b0000000011, "R1 wrapped");
    chk(stamp == 15'h7FFE, "R4 borrow", int'(stamp), 32766);

    // R6: second rise two edges after capture is dropped.
    repeat (3) @(negedge clk);
    last = expect_stamp(bcnt, 5);
    strobe = 1'b1; taps = 10'b0000011111;
    nv = 0;
    for (int j = 1; j <= 8; j++) begin
      @(negedge clk);
      strobe = (j == 2); taps = '0;
      if (vld) nv++;
    end
    chk(nv == 1, "R6 dropped count", nv, 1);
    chk(stamp == last, "R6 stamp kept", int'(stamp), int'(last));

    // R6: rise three edges after capture is accepted.
    last = expect_stamp(bcnt + 12'd3, 4);
    strobe = 1'b1; taps = 10'b0000000001;
    nv = 0;
    for (int j = 1; j <= 9; j++) begin
      @(negedge clk);
      strobe = (j == 3);
      taps = (j == 3) ? 10'b0000001111 : 10'b0;
      if (vld) nv++;
    end
    chk(nv == 2, "R6 accepted count", nv, 2);
    chk(stamp == last, "R6 second stamp", int'(stamp), int'(last));

    // R7: held strobe gives one event.
    strobe = 1'b1; taps = 10'b0000000011;
    nv = 0;
    for (int j = 1; j <= 10; j++) begin
      @(negedge clk);
      if (j == 8) strobe = 1'b0;
      if (vld) nv++;
    end
    chk(nv == 1, "R7 held", nv, 1);

    // R8: reset kills a pending event and clears the counter.
    strobe = 1'b1; taps = 10'b0000000001;
    @(negedge clk); strobe = 1'b0; rst_n = 1'b0;
    nv = 0;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      if (vld) nv++;
    end
    chk(stamp == '0, "R8 stamp cleared", int'(stamp), 0);
    rst_n = 1'b1;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      if (vld) nv++;
    end
    chk(nv == 0, "R8 no stale valid", nv, 0);
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    event_chk(10'b0000000000, "R1 restart at zero");
    chk(stamp == '0, "R8 counter cleared", int'(stamp), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule